// File: doc/BRIEF.md
# Infrared Link Interrupt Status Unit

This block gathers frame-level event pulses from an infrared serial link controller and turns them into a single interrupt line for a host processor. It keeps two event groups. One serves the slow asynchronous serial mode and the other serves the medium and fast framed modes. Each group has a sticky source register, a mask register and a write-one-to-clear register. The group whose mode is currently selected latches the incoming pulses. Two bit positions carry a different meaning in each group: in the slow group they are receive timeout and framing error, and in the framed group they are abort detection and CRC error.

A control register holds the 2-bit link mode field and a master gate for each group. An interrupt is raised only when three conditions all hold: the group is selected by the mode, its master gate is open, and at least one of its latched events is unmasked. The host reaches every register through a plain word-addressed read/write port. Read data is combinational from the address.

The register addresses are: 0 is control, 1 is slow source, 2 is slow mask, 3 is slow clear, 4 is framed source, 5 is framed mask and 6 is framed clear.

Top module: `irLinkIrqUnit`

## Requirements
- R1: Event input index 4 (frame received), 3 (buffer overflow), 2 (timeout/abort), 1 (framing/CRC error) and 0 (frame sent) set source bits 15, 11, 9, 8 and 7 respectively.
- R2: Source bits are sticky: they stay set until cleared, and a write to a source address changes nothing.
- R3: Writing a 1 to a bit at a clear address (3 or 6) clears that source bit of that group, and a 0 leaves the bit untouched.
- R4: When an event pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R5: Control bits 15:14 select the mode. Mode 00 routes events to the slow group, 10 and 11 route them to the framed group, and 01 routes them to neither group.
- R6: Within the selected group, a mask bit at 1 keeps its source bit from raising the interrupt.
- R7: Control bit 0 gates the slow group and bit 4 gates the framed group, where 1 blocks the group. Bit 8 is stored and reads back but has no effect on the interrupt.
- R8: The interrupt depends only on the group the mode selects, and it is 0 in mode 01. The unselected group keeps its latched bits.
- R9: After reset, control reads 0x0111, both mask registers read 0x8B80 and both source registers read 0x0000.
- R10: Bits that are not implemented read 0, and the clear addresses read 0x0000.
- R11: A register write or event pulse takes effect at the next rising clock edge, and the interrupt follows the registered state with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register word address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Combinational read data for regAddr |
| evtPulse | input | 5 | One-cycle event pulses, index order as in R1 |
| irq | output | 1 | Interrupt request |

## Verification
Every result is due exactly one rising edge after its stimulus. The bench drives each write or pulse just after one edge, lets the next edge capture it, and then samples the read data and irq at the following falling edge. Reads need no edge, because the bench sets the address and compares at the same falling edge. The driver queues every expected value with its requirement tag, and a monitor on the falling edge pops the queue and compares, so a result that arrives one cycle late or early shows up as a mismatch.

// File: rtl/irStatPkg.sv
package irStatPkg;
  localparam int REG_W   = 16;
  localparam int NUM_GRP = 2;
  localparam int EVT_N   = 5;
  localparam int REGS_PER_GRP = 3;

  // source bit positions, shared by source/mask/clear registers
  localparam int POS_RXEND = 15;
  localparam int POS_OVF   = 11;
  localparam int POS_ALT9  = 9;
  localparam int POS_ALT8  = 8;
  localparam int POS_TXEND = 7;

  localparam int POS_MODE_LO = 14;
  localparam int GATE_STEP   = 4;   // gate bit of group g sits at g*GATE_STEP
  localparam int POS_GATE_FIFO = 8;

  typedef enum logic [1:0] {
    MODE_SLOW = 2'b00,
    MODE_RSVD = 2'b01,
    MODE_FAST = 2'b10,
    MODE_MED  = 2'b11
  } linkMode_e;

  function automatic logic [REG_W-1:0] spreadEvt(input logic [EVT_N-1:0] e);
    logic [REG_W-1:0] r;
    r = '0;
    r[POS_RXEND] = e[4];
    r[POS_OVF]   = e[3];
    r[POS_ALT9]  = e[2];
    r[POS_ALT8]  = e[1];
    r[POS_TXEND] = e[0];
    return r;
  endfunction

  localparam logic [REG_W-1:0] EVT_BITS  = 16'h8B80;
  localparam logic [REG_W-1:0] CTRL_BITS = 16'hC111;
  localparam logic [REG_W-1:0] CTRL_RST  = 16'h0111;

  // group 0 is the slow serial group, group 1 the framed group
  function automatic logic grpActive(input int g, input logic [1:0] m);
    if (g == 0) return (m == MODE_SLOW);
    return m[1];
  endfunction

  typedef struct packed {
    logic               wrCtrl;
    logic [NUM_GRP-1:0] wrMask;
    logic [NUM_GRP-1:0] wrClr;
    logic               rdCtrl;
    logic [NUM_GRP-1:0] rdSrc;
    logic [NUM_GRP-1:0] rdMask;
  } regStb_t;
endpackage

// File: rtl/irRegCtrl.sv
module irRegCtrl
  import irStatPkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStb_t           stb
);
  always_comb begin
    stb = '0;
    stb.wrCtrl = regWrEn && (regAddr == '0);
    stb.rdCtrl = (regAddr == '0);
    for (int g = 0; g < NUM_GRP; g++) begin
      stb.rdSrc[g]  = (regAddr == ADDR_W'(1 + REGS_PER_GRP*g));
      stb.rdMask[g] = (regAddr == ADDR_W'(2 + REGS_PER_GRP*g));
      stb.wrMask[g] = regWrEn && (regAddr == ADDR_W'(2 + REGS_PER_GRP*g));
      stb.wrClr[g]  = regWrEn && (regAddr == ADDR_W'(3 + REGS_PER_GRP*g));
    end
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrCtrl, stb.wrMask, stb.wrClr})); // R3
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.rdCtrl, stb.rdSrc, stb.rdMask})); // R10
endmodule

// File: rtl/irEvtGroup.sv
module irEvtGroup
  import irStatPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] evtBits,
  input  logic             wrMask,
  input  logic             wrClr,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] src,
  output logic [REG_W-1:0] mask,
  output logic             pending
);
  logic [REG_W-1:0] clrBits;

  assign clrBits = wrClr ? (wrData & EVT_BITS) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      src  <= '0;
      mask <= EVT_BITS;
    end else begin
      src <= ((src & ~clrBits) | evtBits) & EVT_BITS;
      if (wrMask) mask <= wrData & EVT_BITS;
    end
  end

  assign pending = |(src & ~mask);

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (|evtBits) |=> ((src & $past(evtBits & EVT_BITS)) == $past(evtBits & EVT_BITS))); // R4
  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !wrClr |=> ((src & $past(src)) == $past(src))); // R2
  AST_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    wrClr |=> ((src & $past(clrBits & ~evtBits)) == '0)); // R3
  AST_NO_STRAY: assert property (@(posedge clk) disable iff (!rstN)
    ((src | mask) & ~EVT_BITS) == '0); // R10
endmodule

// File: rtl/irStatDatapath.sv
module irStatDatapath
  import irStatPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  regStb_t          stb,
  input  logic [REG_W-1:0] wrData,
  input  logic [EVT_N-1:0] evtPulse,
  output logic [REG_W-1:0] rdData,
  output logic             irq
);
  logic [REG_W-1:0]   ctrlReg;
  logic [1:0]         mode;
  logic [REG_W-1:0]   evtSpread;
  logic [REG_W-1:0]   grpSrc  [NUM_GRP];
  logic [REG_W-1:0]   grpMask [NUM_GRP];
  logic [NUM_GRP-1:0] grpPend;
  logic [NUM_GRP-1:0] grpSel;
  logic [NUM_GRP-1:0] grpIrq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ctrlReg <= CTRL_RST;
    else if (stb.wrCtrl) ctrlReg <= wrData & CTRL_BITS;
  end

  assign mode      = ctrlReg[POS_MODE_LO +: 2];
  assign evtSpread = spreadEvt(evtPulse);

  for (genvar g = 0; g < NUM_GRP; g++) begin : gGrp
    assign grpSel[g] = grpActive(g, mode);

    irEvtGroup i_grp (
      .clk     (clk),
      .rstN    (rstN),
      .evtBits (grpSel[g] ? evtSpread : '0),
      .wrMask  (stb.wrMask[g]),
      .wrClr   (stb.wrClr[g]),
      .wrData  (wrData),
      .src     (grpSrc[g]),
      .mask    (grpMask[g]),
      .pending (grpPend[g])
    );

    assign grpIrq[g] = grpSel[g] && !ctrlReg[g*GATE_STEP] && grpPend[g];
  end

  assign irq = |grpIrq;

  always_comb begin
    rdData = stb.rdCtrl ? ctrlReg : '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (stb.rdSrc[g])  rdData = rdData | grpSrc[g];
      if (stb.rdMask[g]) rdData = rdData | grpMask[g];
    end
  end

  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_RSVD) |-> !irq); // R8
  AST_SLOW_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SLOW && ctrlReg[0]) |-> !irq); // R7
  AST_FAST_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (mode[1] && ctrlReg[GATE_STEP]) |-> !irq); // R7
  AST_IDLE_GROUP: assert property (@(posedge clk) disable iff (!rstN)
    (mode != MODE_SLOW) |=> $stable(grpSrc[0]) || $past(stb.wrClr[0])); // R5
  AST_CTRL_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg & ~CTRL_BITS) == '0); // R10
endmodule

// File: rtl/irLinkIrqUnit.sv
module irLinkIrqUnit
  import irStatPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [EVT_N-1:0]  evtPulse,
  output logic              irq
);
  localparam int LAST_ADDR = REGS_PER_GRP*NUM_GRP;

  regStb_t          stb;
  logic [REG_W-1:0] rdWord;

  initial begin
    assert (DATA_W == REG_W) else $error("data width must equal register width");
    assert ((1 << ADDR_W) > LAST_ADDR) else $error("address width too small");
  end

  irRegCtrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .stb     (stb)
  );

  irStatDatapath i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (REG_W'(regWrData)),
    .evtPulse (evtPulse),
    .rdData   (rdWord),
    .irq      (irq)
  );

  assign regRdData = DATA_W'(rdWord);
endmodule

// File: tb/test_irLinkIrqUnit.sv
module test_irLinkIrqUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [4:0]  evtPulse = '0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    bit          isIrq;
    logic [15:0] exp;
    string       tag;
  } expItem_t;
  expItem_t scoreQ[$];

  always #4 clk = ~clk;

  irLinkIrqUnit i_irLinkIrqUnit (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .evtPulse(evtPulse), .irq(irq)
  );

  // monitor: compares at the falling edge
  always @(negedge clk) begin
    if (scoreQ.size() > 0) begin
      expItem_t it;
      logic [15:0] act;
      it = scoreQ.pop_front();
      act = it.isIrq ? {15'd0, irq} : regRdData;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s: %s actual=%h expected=%h", it.tag,
                 it.isIrq ? "irq" : "read", act, it.exp);
      end
    end
  end

  task automatic cyc(input bit wr, input logic [2:0] a, input logic [15:0] d,
                     input logic [4:0] e);
    @(posedge clk); #1;
    regWrEn = wr; regAddr = a; regWrData = d; evtPulse = e;
    @(posedge clk); #1;
    regWrEn = 1'b0; evtPulse = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    cyc(1'b1, a, d, 5'd0);
  endtask

  task automatic pulse(input logic [4:0] e);
    cyc(1'b0, 3'd0, 16'd0, e);
  endtask

  task automatic expReg(input logic [2:0] a, input logic [15:0] v, input string tag);
    expItem_t it;
    regAddr = a;
    it.isIrq = 0; it.exp = v; it.tag = tag;
    scoreQ.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic expIrq(input bit v, input string tag);
    expItem_t it;
    it.isIrq = 1; it.exp = {15'd0, v}; it.tag = tag;
    scoreQ.push_back(it);
    @(negedge clk); #1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #1;
    // R9 reset values
    expReg(3'd0, 16'h0111, "R9");
    expReg(3'd2, 16'h8B80, "R9");
    expReg(3'd5, 16'h8B80, "R9");
    expReg(3'd1, 16'h0000, "R9");
    expReg(3'd4, 16'h0000, "R9");
    expIrq(1'b0, "R9");
    // R10 unimplemented bits and clear address
    wr(3'd0, 16'h3EEE);
    expReg(3'd0, 16'h0000, "R10");
    expReg(3'd3, 16'h0000, "R10");
    wr(3'd2, 16'hFFFF);
    expReg(3'd2, 16'h8B80, "R10");
    // slow mode, slow gate open, framed gate closed
    wr(3'd0, 16'h0110);
    pulse(5'b10000);
    expReg(3'd1, 16'h8000, "R1");
    expReg(3'd4, 16'h0000, "R5");
    expIrq(1'b0, "R6");
    wr(3'd2, 16'h0000);
    expIrq(1'b1, "R6");
    wr(3'd2, 16'h8000);
    expIrq(1'b0, "R6");
    wr(3'd2, 16'h0000);
    // R2 source writes ignored and bits stay
    wr(3'd1, 16'h0000);
    expReg(3'd1, 16'h8000, "R2");
    repeat (4) @(posedge clk);
    #1 expReg(3'd1, 16'h8000, "R2");
    // R1 positions
    pulse(5'b01000); expReg(3'd1, 16'h8800, "R1");
    pulse(5'b00100); expReg(3'd1, 16'h8A00, "R1");
    pulse(5'b00010); expReg(3'd1, 16'h8B00, "R1");
    pulse(5'b00001); expReg(3'd1, 16'h8B80, "R1");
    // R3 clear
    wr(3'd3, 16'h0800);
    expReg(3'd1, 16'h8380, "R3");
    // R4 event beats clear
    cyc(1'b1, 3'd3, 16'h8000, 5'b10000);
    expReg(3'd1, 16'h8380, "R4");
    cyc(1'b1, 3'd3, 16'h0100, 5'b10000);
    expReg(3'd1, 16'h8280, "R4");
    // R7 master gates
    wr(3'd0, 16'h0111);
    expIrq(1'b0, "R7");
    wr(3'd0, 16'h0010);
    expIrq(1'b1, "R7");
    expReg(3'd0, 16'h0010, "R7");
    // R5/R8 framed group
    wr(3'd0, 16'hC010);
    expIrq(1'b0, "R8");
    pulse(5'b00100);
    expReg(3'd4, 16'h0200, "R5");
    expReg(3'd1, 16'h8280, "R5");
    wr(3'd5, 16'h0000);
    expIrq(1'b0, "R7");
    wr(3'd0, 16'hC001);
    expIrq(1'b1, "R8");
    wr(3'd0, 16'h8001);
    expIrq(1'b1, "R5");
    wr(3'd0, 16'h4000);
    expIrq(1'b0, "R8");
    pulse(5'b11111);
    expReg(3'd1, 16'h8280, "R5");
    expReg(3'd4, 16'h0200, "R5");
    // back to slow mode
    wr(3'd0, 16'h0000);
    expIrq(1'b1, "R8");
    wr(3'd3, 16'hFFFF);
    expReg(3'd1, 16'h0000, "R3");
    expIrq(1'b0, "R3");
    // R11 one-edge latency
    pulse(5'b00001);
    expIrq(1'b1, "R11");
    expReg(3'd1, 16'h0080, "R11");
    @(negedge clk); #1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule